// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host a two-address window into a small bank of byte-wide configuration registers over a plain synchronous 8-bit I/O bus. The host first writes a register number to the index address. A following access to the data address then reads or writes the register that number selects. The index is held until the host writes it again, so a run of data accesses keeps hitting the same register.

The bank holds eighteen registers. Most of them store every bit written. Two registers have hard-wired masks that force some bits to zero. Three registers are exported straight to the memory-shadowing logic. One register drives an external-cache-enable line, which is high when either of two of its bits is set.

Reads are combinational and have no side effects. A read returns all ones when it targets the index address, when the index is out of range, or when no data read is in progress.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the stored index is 0x00, every register reads 0x00, all three shadow outputs are 0x00 and `ext_cache_en` is 0.
- R2: A write strobe at address 0x22 stores `io_wdata` as the index on the clock edge. The index stays unchanged through any number of data-port reads and writes, until the next write to 0x22.
- R3: A write strobe at address 0x24 with index below 0x12 (18) stores the written byte into the selected register on the clock edge. A read of 0x24 in a later cycle returns that byte.
- R4: Register 0x00 stores only bits [6:0], so its bit 7 always reads 0.
- R5: Register 0x0C stores only the bits in mask 0xCF, so its bits 5 and 4 always read 0.
- R6: A data write with an index of 0x12 or above changes no register and no output.
- R7: While `io_rd` is high at address 0x24, `io_rdata` shows the selected register in that same cycle when the index is below 0x12, and 0xFF otherwise.
- R8: A read at address 0x22 returns 0xFF, whatever index is stored.
- R9: `ext_cache_en` is 1 exactly when bit 2 or bit 3 of register 0x02 is 1.
- R10: `shadow_seg_c`, `shadow_seg_d` and `shadow_seg_ef` equal registers 0x04, 0x05 and 0x06. Each follows a write in the cycle after the clock edge that takes it, and changes at no other time.
- R11: Write strobes at any address other than 0x22 or 0x24 change neither the index nor any register. `io_rdata` is 0xFF whenever no data-port read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, taken on the rising edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| shadow_seg_c | output | 8 | Copy of register 0x04 |
| shadow_seg_d | output | 8 | Copy of register 0x05 |
| shadow_seg_ef | output | 8 | Copy of register 0x06 |
| ext_cache_en | output | 1 | External cache enable, from register 0x02 |

## Verification
The bench writes all ones to the two masked registers. A design that dropped a mask would read back 0xFF instead of 0x7F or 0xCF. It writes with the index at 0x12 and 0xFF, then reads back the whole bank. A decoder that wraps the index or truncates it would corrupt a low register, and the readback would show it. It sets each cache bit alone and then clears both, which catches a derivation that tests only one bit or requires both. It also checks that the index survives many data accesses and that an index-port read returns 0xFF rather than the stored index.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned IDX_ZERO  = 0;
  localparam int unsigned IDX_DMA   = 12;
  localparam int unsigned IDX_CACHE = 2;
  localparam int unsigned IDX_SH_C  = 4;
  localparam int unsigned IDX_SH_D  = 5;
  localparam int unsigned IDX_SH_EF = 6;

  // Bits that a register keeps on a write.
  function automatic logic [BYTE_W-1:0] keep_mask(input int unsigned idx);
    if (idx == IDX_ZERO)     keep_mask = 8'h7F;
    else if (idx == IDX_DMA) keep_mask = 8'hCF;
    else                     keep_mask = 8'hFF;
  endfunction

  // The cache is on when either of the two enable bits is set.
  function automatic logic cache_on(input logic [BYTE_W-1:0] v);
    cache_on = v[2] | v[3];
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned IDX_ADDR  = 'h22,
  parameter int unsigned DATA_ADDR = 'h24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              idx_wr,
  output logic              data_wr,
  output logic              data_rd
);
  logic at_idx;
  logic at_data;

  always_comb begin
    at_idx  = (addr == ADDR_W'(IDX_ADDR));
    at_data = (addr == ADDR_W'(DATA_ADDR));
    idx_wr  = wr & at_idx;
    data_wr = wr & at_data;
    data_rd = rd & at_data;
  end
endmodule

// File: rtl/cfg_index_latch.sv
module cfg_index_latch #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] din,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= din;
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
#(
  parameter int unsigned N_REGS = 18,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [BYTE_W-1:0]             wdata,
  output logic [N_REGS-1:0][BYTE_W-1:0] regs
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] KEEP = keep_mask(g);
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   regs[g] <= '0;
      else if (sel) regs[g] <= wdata & KEEP;
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned N_REGS    = 18,
  parameter int unsigned IDX_ADDR  = 'h22,
  parameter int unsigned DATA_ADDR = 'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [7:0]        shadow_seg_c,
  output logic [7:0]        shadow_seg_d,
  output logic [7:0]        shadow_seg_ef,
  output logic              ext_cache_en
);
  localparam int unsigned IDX_W = BYTE_W;

  logic                          hit_idx_wr;
  logic                          hit_data_wr;
  logic                          hit_data_rd;
  logic [IDX_W-1:0]              cur_idx;
  logic                          idx_valid;
  logic                          bank_wr;
  logic [N_REGS-1:0][BYTE_W-1:0] regs;

  cfg_addr_decode #(
    .ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .addr(io_addr), .wr(io_wr), .rd(io_rd),
    .idx_wr(hit_idx_wr), .data_wr(hit_data_wr), .data_rd(hit_data_rd)
  );

  cfg_index_latch #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(hit_idx_wr), .din(io_wdata), .idx(cur_idx)
  );

  assign idx_valid = (32'(cur_idx) < N_REGS);
  assign bank_wr   = hit_data_wr & idx_valid;

  cfg_reg_bank #(.N_REGS(N_REGS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bank_wr), .wr_idx(cur_idx),
    .wdata(io_wdata), .regs(regs)
  );

  always_comb begin
    io_rdata = 8'hFF;
    if (hit_data_rd && idx_valid) io_rdata = regs[cur_idx];
  end

  assign shadow_seg_c  = regs[IDX_SH_C];
  assign shadow_seg_d  = regs[IDX_SH_D];
  assign shadow_seg_ef = regs[IDX_SH_EF];
  assign ext_cache_en  = cache_on(regs[IDX_CACHE]);
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned IDX_ADDR  = 'h22,
  parameter int unsigned DATA_ADDR = 'h24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic [7:0]        shadow_seg_c,
  input logic [7:0]        shadow_seg_d,
  input logic [7:0]        shadow_seg_ef,
  input logic              ext_cache_en,
  input logic              hit_idx_wr,
  input logic              hit_data_wr,
  input logic [7:0]        cur_idx
);
  logic rd_idx_port;
  logic rd_data_port;
  logic sh_write;
  logic cache_write;

  assign rd_idx_port  = io_rd && (io_addr == ADDR_W'(IDX_ADDR));
  assign rd_data_port = io_rd && (io_addr == ADDR_W'(DATA_ADDR));
  assign sh_write     = hit_data_wr && (cur_idx >= 8'd4) && (cur_idx <= 8'd6);
  assign cache_write  = hit_data_wr && (cur_idx == 8'd2);

  assert_idx_read_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_port |-> io_rdata == 8'hFF);
  assert_oob_read_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_port && cur_idx >= 8'd18) |-> io_rdata == 8'hFF);
  assert_reg0_top_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_port && cur_idx == 8'd0) |-> !io_rdata[7]);
  assert_reg0c_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_port && cur_idx == 8'd12) |-> io_rdata[5:4] == 2'b00);
  assert_index_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hit_idx_wr) |-> $stable(cur_idx));
  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sh_write) |-> ($stable(shadow_seg_c) && $stable(shadow_seg_d) && $stable(shadow_seg_ef)));
  assert_cache_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cache_write) |-> $stable(ext_cache_en));
  assert_idle_read_ff_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data_port |-> io_rdata == 8'hFF);
endmodule

bind cfg_index_port cfg_index_port_chk #(
  .ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_rdata(io_rdata),
  .shadow_seg_c(shadow_seg_c), .shadow_seg_d(shadow_seg_d), .shadow_seg_ef(shadow_seg_ef),
  .ext_cache_en(ext_cache_en), .hit_idx_wr(hit_idx_wr), .hit_data_wr(hit_data_wr),
  .cur_idx(cur_idx)
);

// File: tb/cfg_index_port_test.sv
module cfg_index_port_test;
  localparam logic [15:0] A_IDX  = 16'h0022;
  localparam logic [15:0] A_DATA = 16'h0024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [7:0]  shadow_seg_c, shadow_seg_d, shadow_seg_ef;
  logic        ext_cache_en;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] model [18];

  always #10 clk = ~clk;

  cfg_index_port uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .shadow_seg_c(shadow_seg_c),
    .shadow_seg_d(shadow_seg_d), .shadow_seg_ef(shadow_seg_ef), .ext_cache_en(ext_cache_en)
  );

  function automatic logic [7:0] kept(input int idx, input logic [7:0] v);
    if (idx == 0)  return {1'b0, v[6:0]};
    if (idx == 12) return {v[7:6], 2'b00, v[3:0]};
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic set_reg(input int idx, input logic [7:0] v);
    io_write(A_IDX, 8'(idx));
    io_write(A_DATA, v);
    if (idx < 18) model[idx] = kept(idx, v);
  endtask

  task automatic check_bank(input string req);
    logic [7:0] d;
    for (int i = 0; i < 18; i++) begin
      io_write(A_IDX, 8'(i));
      io_read(A_DATA, d);
      check(req, d, model[i]);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int i = 0; i < 18; i++) model[i] = 8'h00;
    io_read(A_DATA, d);
    check("R1 index 0 reg", d, 8'h00);
    check("R1 shadow c", shadow_seg_c, 8'h00);
    check("R1 shadow d", shadow_seg_d, 8'h00);
    check("R1 shadow ef", shadow_seg_ef, 8'h00);
    check("R1 cache", {7'd0, ext_cache_en}, 8'h00);
    check_bank("R1 bank");
  endtask

  task automatic t_write_persist;
    logic [7:0] d;
    for (int i = 0; i < 18; i++) set_reg(i, 8'(8'h30 + i * 7));
    check_bank("R3 readback");
    io_write(A_IDX, 8'h09);
    io_write(A_DATA, 8'hA5);
    io_read(A_DATA, d);
    io_write(A_DATA, 8'h5A);
    io_read(A_DATA, d);
    io_write(A_DATA, 8'h3C);
    model[9] = 8'h3C;
    io_read(A_DATA, d);
    check("R2 index persists", d, 8'h3C);
    check_bank("R2 only reg 9 hit");
  endtask

  task automatic t_masks;
    logic [7:0] d;
    set_reg(0, 8'hFF);
    io_read(A_DATA, d);
    check("R4 reg0 mask", d, 8'h7F);
    set_reg(12, 8'hFF);
    io_read(A_DATA, d);
    check("R5 reg0C mask", d, 8'hCF);
    set_reg(12, 8'h30);
    io_read(A_DATA, d);
    check("R5 reg0C bits 5:4", d, 8'h00);
  endtask

  task automatic t_out_of_range;
    logic [7:0] d;
    io_write(A_IDX, 8'h12);
    io_write(A_DATA, 8'hEE);
    io_read(A_DATA, d);
    check("R7 index 0x12 read", d, 8'hFF);
    io_write(A_IDX, 8'hFF);
    io_write(A_DATA, 8'h11);
    io_read(A_DATA, d);
    check("R7 index 0xFF read", d, 8'hFF);
    check_bank("R6 bank unchanged");
  endtask

  task automatic t_index_read;
    logic [7:0] d;
    io_write(A_IDX, 8'h03);
    io_read(A_IDX, d);
    check("R8 index port read", d, 8'hFF);
    io_read(A_DATA, d);
    check("R8 index kept", d, model[3]);
  endtask

  task automatic t_cache;
    set_reg(2, 8'h04);
    check("R9 bit2", {7'd0, ext_cache_en}, 8'h01);
    set_reg(2, 8'h08);
    check("R9 bit3", {7'd0, ext_cache_en}, 8'h01);
    set_reg(2, 8'hF3);
    check("R9 neither", {7'd0, ext_cache_en}, 8'h00);
  endtask

  task automatic t_shadow;
    set_reg(4, 8'h81);
    set_reg(5, 8'h42);
    set_reg(6, 8'h0F);
    check("R10 shadow c", shadow_seg_c, 8'h81);
    check("R10 shadow d", shadow_seg_d, 8'h42);
    check("R10 shadow ef", shadow_seg_ef, 8'h0F);
    set_reg(7, 8'h99);
    check("R10 shadow c held", shadow_seg_c, 8'h81);
  endtask

  task automatic t_other_addr;
    logic [7:0] d;
    io_write(A_IDX, 8'h05);
    io_write(16'h0023, 8'h01);
    io_write(16'h0124, 8'h77);
    io_write(16'h0025, 8'h66);
    check("R11 idle rdata", io_rdata, 8'hFF);
    io_read(A_DATA, d);
    check("R11 other addr ignored", d, model[5]);
    check_bank("R11 bank");
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_write_persist();
    t_masks();
    t_out_of_range();
    t_index_read();
    t_cache();
    t_shadow();
    t_other_addr();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule